// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer ALU of parameterized width, assembled from identical one-bit slices. Every slice holds a two-input AND, a two-input OR and a full adder. Either operand bit can be inverted before it reaches these gates. A four-way selector then picks the slice output. The carries pass from each slice to the next, so the adder is a plain ripple chain.

Software-visible operations come from a 4-bit control word with three fields. Bit 3 inverts A, bit 2 inverts B, and bits 1:0 choose the slice output: 00 gives AND, 01 gives OR, 10 gives the adder sum and 11 gives the slice's less input. The invert-B bit also supplies the carry into slice 0, so inverting B turns the add into a subtract. The top slice's sum bit is its set output. That bit is routed back to the less input of slice 0, and the less inputs of all other slices are tied low. This is how set-less-than is formed.

The outputs are the result, a zero flag for equality tests, a signed overflow flag and the carry out of the top slice. A branch unit tests two operands for equality by issuing a subtract and reading the zero flag.

Top module: `alu_bitslice`

## Requirements
- R1: Control 0000 (invert-A 0, invert-B 0, select 00) drives result_o to A AND B.
- R2: Control 0001 drives result_o to A OR B.
- R3: Control 0010 drives result_o to A+B modulo 2^W, and carry_o to the unsigned carry out of bit W-1.
- R4: Control 0110 drives result_o to A-B modulo 2^W. The carry into slice 0 is 1, so carry_o is 1 exactly when A >= B taken as unsigned numbers.
- R5: Control 1100 drives result_o to NOT (A OR B).
- R6: Control 0111 drives result_o bit 0 to bit W-1 of A-B and all other result bits to 0. When the subtraction overflows, this answer is the wrong signed comparison (for example, the most negative value against 1 yields 0), and that outcome is the intended behaviour.
- R7: zero_o is 1 exactly when every bit of result_o is 0, for every control code. A subtract of equal operands therefore raises it.
- R8: For controls 0010 and 0110, ovf_o is 1 exactly when the signed result does not fit in W bits. This equals the carry into the top slice XOR the carry out of the top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| ctrl_i | input | 4 | Bit 3 inverts A, bit 2 inverts B and supplies the carry into slice 0, bits 1:0 select the slice output |
| result_o | output | W | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of the top slice adder |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
The ALU holds no state, so every output is due in the same cycle as its operands and control. The bench changes the inputs at the falling clock edge and compares all four outputs against a behavioural model just before the next rising edge. The full ripple has settled by then, and each clock carries exactly one stimulus and one comparison. The carry and overflow flags are compared only for add and subtract. The stimulus crosses the corner operands (zero, all ones, the most negative value, the most positive value, one) with every listed operation, and then runs random operands.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;

  // Output choice inside one slice; the encoding is the low two control bits.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  localparam int unsigned CTRL_W     = 4;
  localparam int unsigned CTRL_INV_A = 3;
  localparam int unsigned CTRL_INV_B = 2;

  localparam logic [CTRL_W-1:0] OP_AND = 4'b0000;
  localparam logic [CTRL_W-1:0] OP_OR  = 4'b0001;
  localparam logic [CTRL_W-1:0] OP_ADD = 4'b0010;
  localparam logic [CTRL_W-1:0] OP_SUB = 4'b0110;
  localparam logic [CTRL_W-1:0] OP_SLT = 4'b0111;
  localparam logic [CTRL_W-1:0] OP_NOR = 4'b1100;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_bitslice_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic a_eff;
  logic b_eff;
  logic sum;

  always_comb begin
    a_eff  = a_i ^ inv_a_i;
    b_eff  = b_i ^ inv_b_i;
    sum    = a_eff ^ b_eff ^ cin_i;
    cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);
  end

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

  // Only the most significant slice carries the sign and overflow logic.
  generate
    if (IS_TOP) begin : g_top
      always_comb begin
        set_o = sum;
        ovf_o = cin_i ^ cout_o;
      end
    end else begin : g_mid
      always_comb begin
        set_o = 1'b0;
        ovf_o = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic         zero_o
);

  always_comb begin
    zero_o = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (vec_i[k]) zero_o = 1'b0;
    end
  end

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_bitslice_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [W-1:0]      result_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              carry_o
);

  localparam int unsigned MSB = W - 1;

  logic       inv_a;
  logic       inv_b;
  slice_sel_e sel;
  logic       set_top;

  always_comb begin
    inv_a = ctrl_i[CTRL_INV_A];
    inv_b = ctrl_i[CTRL_INV_B];
    sel   = slice_sel_e'(ctrl_i[1:0]);
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      logic cin;
      logic cout;
      logic less;
      logic set;
      logic ovf;

      if (i == 0) begin : g_lsb
        assign cin  = inv_b;
        assign less = set_top;
      end else begin : g_upper
        assign cin  = g_slice[i-1].cout;
        assign less = 1'b0;
      end

      alu_slice #(
        .IS_TOP (i == MSB)
      ) u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (cin),
        .less_i  (less),
        .sel_i   (sel),
        .res_o   (result_o[i]),
        .cout_o  (cout),
        .set_o   (set),
        .ovf_o   (ovf)
      );
    end
  endgenerate

  assign set_top = g_slice[MSB].set;
  assign carry_o = g_slice[MSB].cout;
  assign ovf_o   = g_slice[MSB].ovf;

  alu_zero_detect #(
    .W (W)
  ) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk
  import alu_bitslice_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [W-1:0]      result_o,
  input logic              zero_o,
  input logic              ovf_o,
  input logic              carry_o
);

  logic [W:0]   wide_sum;
  logic [W-1:0] diff;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    diff     = a_i - b_i;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, ctrl_i})) begin
      a_r7_zero_flag: assert (zero_o == (result_o == '0));
      if (ctrl_i == OP_ADD) begin
        a_r3_add_sum: assert ({carry_o, result_o} == wide_sum);
        a_r8_add_overflow: assert (ovf_o ==
          ((a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1])));
      end
      if (ctrl_i == OP_SUB) begin
        a_r4_sub_diff: assert (result_o == diff && carry_o == (a_i >= b_i));
        a_r8_sub_overflow: assert (ovf_o ==
          ((a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1])));
      end
      if (ctrl_i == OP_SLT) begin
        a_r6_slt_shape: assert (result_o[W-1:1] == '0 && result_o[0] == diff[W-1]);
      end
    end
  end

endmodule

bind alu_bitslice alu_bitslice_chk #(.W(W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .ctrl_i   (ctrl_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o),
  .carry_o  (carry_o)
);

// File: tb/test_alu_bitslice.sv
module test_alu_bitslice;

  localparam int W = 32;
  localparam int WDOG_LIMIT = 150000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [3:0]   ctrl;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;
  logic         carry;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  alu_bitslice #(.W(W)) i_alu_bitslice (
    .a_i      (a),
    .b_i      (b),
    .ctrl_i   (ctrl),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf),
    .carry_o  (carry)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1 and";
      4'b0001: return "R2 or";
      4'b0010: return "R3/R8 add";
      4'b0110: return "R4/R8 sub";
      4'b0111: return "R6 slt";
      4'b1100: return "R5 nor";
      default: return "other";
    endcase
  endfunction

  task automatic check_field(input string req, input string name,
                             input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: a=%h b=%h actual %h expected %h", req, name, a, b, act, exp);
    end
  endtask

  // Drive at the falling edge, compare just before the next rising edge.
  task automatic apply(input logic [3:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0]   s;
    logic [W-1:0] d;
    logic [W-1:0] exp_res;
    logic         exp_c;
    logic         exp_v;
    bit           flags;
    @(negedge clk);
    ctrl = op; a = x; b = y;
    s = {1'b0, x} + {1'b0, y};
    d = x - y;
    exp_c = 1'b0; exp_v = 1'b0; flags = 0;
    case (op)
      4'b0000: exp_res = x & y;
      4'b0001: exp_res = x | y;
      4'b1100: exp_res = ~(x | y);
      4'b0010: begin
        exp_res = s[W-1:0]; exp_c = s[W]; flags = 1;
        exp_v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      4'b0110: begin
        exp_res = d; exp_c = (x >= y); flags = 1;
        exp_v = (x[W-1] != y[W-1]) && (d[W-1] != x[W-1]);
      end
      4'b0111: exp_res = {{(W-1){1'b0}}, d[W-1]};
      default: exp_res = '0;
    endcase
    #4;
    check_field(req_of(op), "result", result, exp_res);
    check_field("R7", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, exp_res == '0});
    if (flags) begin
      check_field(req_of(op), "carry", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, exp_c});
      check_field("R8", "ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_v});
    end
  endtask

  initial begin
    logic [W-1:0] corners [5];
    logic [3:0]   ops     [6];
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b1, {(W-1){1'b0}}};
    corners[3] = {1'b0, {(W-1){1'b1}}};
    corners[4] = {{(W-1){1'b0}}, 1'b1};
    ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
    ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;

    rst_n = 1'b0; a = '0; b = '0; ctrl = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero operands under AND give a zero result with zero_o high (R1, R7).
    @(negedge clk); #4;
    check_field("R1 idle", "result", result, '0);
    check_field("R7 idle", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

    // R6: the subtraction overflows, so the sign bit gives 0 although A < B signed.
    apply(4'b0111, corners[2], corners[4]);
    check_field("R6 slt overflow", "result", result, '0);
    // R6: 0x7fff_ffff vs all ones (-1): the difference wraps negative, giving 1.
    apply(4'b0111, corners[3], corners[1]);
    check_field("R6 slt overflow", "result", result, {{(W-1){1'b0}}, 1'b1});
    // R7: a subtract of equal operands raises zero_o.
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);
    check_field("R7 equal sub", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
    // R8: the most positive value plus one overflows.
    apply(4'b0010, corners[3], corners[4]);
    check_field("R8 add overflow", "ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, 1'b1});

    foreach (ops[o]) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply(ops[o], corners[i], corners[j]);
        end
      end
    end

    for (int n = 0; n < 400; n++) begin
      for (int o = 0; o < 6; o++) begin
        apply(ops[o], $urandom(), $urandom());
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule